// File: doc/BRIEF.md
# Bit-Operation Control Register Bank

This block is a bank of 32-bit control registers on a simple synchronous bus. Every register owns a 16-byte address slot. Inside that slot the word offset picks the kind of write: a plain overwrite, an atomic OR, an atomic AND-NOT or an atomic XOR of the write data. Software can therefore flip, raise or drop single control bits in one bus write, with no read-modify-write sequence and no race against other agents. A read at any of the four word offsets of a slot returns the stored value.

A read-only identification word can be mapped at a chosen address. Its decode wins over any bank slot it overlaps. An access whose slot number lies beyond the last register raises a single-cycle error pulse and changes nothing. Read data and the error pulse are registered and appear one clock after the request. A write takes effect on the clock edge where it is presented.

Top module: `sct_bank`

## Requirements
- R1: The register slot number is `addr[ADDR_W-1:4]`, so registers sit 16 bytes apart. A write to one slot leaves every other slot unchanged.
- R2: A write with `addr[3:0] == 4'h0` replaces the addressed register with `wr_data` on the clock edge where it is presented.
- R3: A write with `addr[3:0] == 4'h4` ORs `wr_data` into the addressed register.
- R4: A write with `addr[3:0] == 4'h8` clears every register bit that is 1 in `wr_data`.
- R5: A write with `addr[3:0] == 4'hC` inverts every register bit that is 1 in `wr_data`.
- R6: A read at any of the four word offsets (0x0, 0x4, 0x8, 0xC) returns the stored value on `rd_data` one clock after `rd_en`. `rd_data` holds its value while `rd_en` is low.
- R7: Synchronous reset clears every register, `rd_data` and `err` to zero.
- R8: When `HAS_ID` is 1, a read at exactly `ID_ADDR` returns `ID_VALUE` (default 0x00720010), even where that address falls inside a bank slot. A write to `ID_ADDR` changes no register.
- R9: An access with `addr[1:0] != 0` is not a word access. Such a write changes nothing, and such a read returns zero.
- R10: An access (read or write) whose slot number is NUM_REGS or above, and that is not at `ID_ADDR`, drives `err` high for exactly the one cycle after it. Such a write changes nothing, and such a read returns zero. `err` stays low after a cycle with no access.
- R11: When a read and a write address the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data or bit mask |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle out-of-range pulse |

## Verification
The hardest case to reach is the identification word shadowing a live bank slot. With the default parameters the two never overlap. The bench therefore places `ID_ADDR` on the OR offset of the last slot. It then shows three things at the ports: a write there leaves that register untouched, the plain offset of the same slot still reads and writes normally, and the ID read still wins afterwards. The same-cycle read-and-write case is driven by raising both enables in one cycle at one address, and the check confirms that the returned word is the old one.

// File: rtl/sct_pkg.sv
package sct_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } bitop_e;

    typedef struct packed {
        logic   hit_id;
        logic   in_range;
        logic   aligned;
        bitop_e op;
    } dec_t;

    function automatic logic [DATA_W-1:0] apply_bitop(
        input bitop_e            op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] mask
    );
        logic [DATA_W-1:0] nxt;
        unique case (op)
            OP_WRITE:  nxt = mask;
            OP_SET:    nxt = cur | mask;
            OP_CLEAR:  nxt = cur & ~mask;
            OP_TOGGLE: nxt = cur ^ mask;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sct_decode.sv
module sct_decode
    import sct_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          NUM_REGS = 8,
    parameter bit          HAS_ID   = 1'b1,
    parameter logic [11:0] ID_ADDR  = 12'h800,
    localparam int         SLOT_W   = ADDR_W - 4,
    localparam int         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(NUM_REGS);

    logic [SLOT_W-1:0] slot;

    assign slot         = addr[ADDR_W-1:4];
    assign idx          = slot[IDX_W-1:0];
    assign dec.in_range = ({1'b0, slot} < LIMIT);
    assign dec.aligned  = (addr[1:0] == 2'b00);
    assign dec.op       = bitop_e'(addr[3:2]);

    generate
        if (HAS_ID) begin : g_id
            assign dec.hit_id = (addr == ID_ADDR[ADDR_W-1:0]);
        end else begin : g_no_id
            assign dec.hit_id = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sct_regfile.sv
module sct_regfile
    import sct_pkg::*;
#(
    parameter int  NUM_REGS = 8,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 widx,
    input  bitop_e                           wop,
    input  logic [DATA_W-1:0]                wmask,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= '0;
                end else if (we && (widx == IDX_W'(i))) begin
                    regs[i] <= apply_bitop(wop, regs[i], wmask);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sct_bank.sv
module sct_bank
    import sct_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          NUM_REGS = 8,
    parameter bit          HAS_ID   = 1'b1,
    parameter logic [11:0] ID_ADDR  = 12'h800,
    parameter logic [31:0] ID_VALUE = 32'h0072_0010,
    localparam int         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              err
);
    dec_t                             dec;
    logic [IDX_W-1:0]                 idx;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;
    logic                             commit;
    logic                             word_ok;
    logic [31:0]                      rd_next;
    logic [31:0]                      rd_q;
    logic                             err_q;

    sct_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .HAS_ID   (HAS_ID),
        .ID_ADDR  (ID_ADDR)
    ) u_dec (
        .addr (addr),
        .dec  (dec),
        .idx  (idx)
    );

    assign word_ok = dec.in_range && dec.aligned && !dec.hit_id;
    assign commit  = wr_en && word_ok;

    sct_regfile #(
        .NUM_REGS (NUM_REGS)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .widx  (idx),
        .wop   (dec.op),
        .wmask (wr_data),
        .regs  (regs_q)
    );

    always_comb begin
        if (dec.hit_id)   rd_next = ID_VALUE;
        else if (word_ok) rd_next = regs_q[idx];
        else              rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (rd_en) rd_q <= rd_next;
            err_q <= (rd_en || wr_en) && !dec.in_range && !dec.hit_id;
        end
    end

    assign rd_data = rd_q;
    assign err     = err_q;

endmodule

// File: rtl/sct_bank_chk.sv
module sct_bank_chk #(
    parameter int          ADDR_W   = 12,
    parameter int          NUM_REGS = 8,
    parameter bit          HAS_ID   = 1'b1,
    parameter logic [11:0] ID_ADDR  = 12'h800,
    parameter logic [31:0] ID_VALUE = 32'h0072_0010,
    localparam int         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           addr,
    input logic                        wr_en,
    input logic [31:0]                 wr_data,
    input logic                        rd_en,
    input logic [31:0]                 rd_data,
    input logic                        err,
    input logic [NUM_REGS-1:0][31:0]   regs
);
    localparam logic [ADDR_W-4:0] LIM = (ADDR_W-3)'(NUM_REGS);

    logic             inrng;
    logic             is_id;
    logic [IDX_W-1:0] slot;

    assign inrng = ({1'b0, addr[ADDR_W-1:4]} < LIM);
    assign is_id = HAS_ID && (addr == ID_ADDR[ADDR_W-1:0]);
    assign slot  = addr[IDX_W+3:4];

    AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:0] == 4'h0 && inrng && !is_id)
        |=> regs[$past(slot)] == $past(wr_data)); // R2

    AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:0] == 4'h4 && inrng && !is_id)
        |=> (regs[$past(slot)] & $past(wr_data)) == $past(wr_data)); // R3

    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:0] == 4'h8 && inrng && !is_id)
        |=> (regs[$past(slot)] & $past(wr_data)) == 32'h0); // R4

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_id) |=> rd_data == ID_VALUE); // R8

    AST_ID_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_id) |=> $stable(regs)); // R8

    AST_UNALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00 && !is_id) |=> rd_data == 32'h0); // R9

    AST_OOR_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inrng && !is_id) |=> $stable(regs)); // R10

    AST_OOR_ERR: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && !inrng && !is_id) |=> err); // R10

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |=> !err); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs == '0 && rd_data == 32'h0 && !err)); // R7

endmodule

bind sct_bank sct_bank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .HAS_ID   (HAS_ID),
    .ID_ADDR  (ID_ADDR),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .err     (err),
    .regs    (regs_q)
);

// File: tb/sct_bank_test.sv
`timescale 1ns/1ps
module sct_bank_test;

    localparam int          ADDR_W = 12;
    localparam int          NREG   = 8;
    localparam logic [11:0] IDA    = 12'h074;
    localparam logic [31:0] IDV    = 32'h0072_0010;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic              err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sct_bank #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NREG),
        .HAS_ID   (1'b1),
        .ID_ADDR  (IDA),
        .ID_VALUE (IDV)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .err     (err)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 12'h010, 32'hA5A5_0000, 32'h0,          1'b0, 8'd2 },  // R2 plain write slot 1
        '{1'b0, 1'b1, 12'h018, 32'h0,         32'hA5A5_0000, 1'b0, 8'd6 },  // R6 read at clear offset
        '{1'b1, 1'b0, 12'h014, 32'h0000_00FF, 32'h0,          1'b0, 8'd3 },  // R3 set
        '{1'b0, 1'b1, 12'h01C, 32'h0,         32'hA5A5_00FF, 1'b0, 8'd3 },  // R3
        '{1'b1, 1'b0, 12'h018, 32'hA000_000F, 32'h0,          1'b0, 8'd4 },  // R4 clear
        '{1'b0, 1'b1, 12'h010, 32'h0,         32'h05A5_00F0, 1'b0, 8'd4 },  // R4
        '{1'b1, 1'b0, 12'h01C, 32'hFFFF_0000, 32'h0,          1'b0, 8'd5 },  // R5 toggle
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'hFA5A_00F0, 1'b0, 8'd5 },  // R5
        '{1'b1, 1'b0, 12'h012, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd9 },  // R9 unaligned write
        '{1'b0, 1'b1, 12'h010, 32'h0,         32'hFA5A_00F0, 1'b0, 8'd9 },  // R9 unchanged
        '{1'b0, 1'b1, 12'h016, 32'h0,         32'h0,          1'b0, 8'd9 },  // R9 unaligned read zero
        '{1'b1, 1'b0, 12'h080, 32'h1234_5678, 32'h0,          1'b1, 8'd10},  // R10 out-of-range write
        '{1'b0, 1'b1, 12'h000, 32'h0,         32'h0,          1'b0, 8'd10},  // R10 no wrap onto slot 0
        '{1'b0, 1'b1, 12'h0F0, 32'h0,         32'h0,          1'b1, 8'd10},  // R10 out-of-range read
        '{1'b0, 1'b1, 12'h074, 32'h0,         32'h0072_0010, 1'b0, 8'd8 },  // R8 ID read
        '{1'b1, 1'b0, 12'h074, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd8 },  // R8 ID write
        '{1'b0, 1'b1, 12'h074, 32'h0,         32'h0072_0010, 1'b0, 8'd8 },  // R8 ID unchanged
        '{1'b0, 1'b1, 12'h070, 32'h0,         32'h0,          1'b0, 8'd8 },  // R8 shadowed slot untouched
        '{1'b1, 1'b0, 12'h070, 32'h0000_0011, 32'h0,          1'b0, 8'd1 },  // R1 last slot write
        '{1'b0, 1'b1, 12'h07C, 32'h0,         32'h0000_0011, 1'b0, 8'd1 },  // R1
        '{1'b1, 1'b1, 12'h020, 32'h0000_0055, 32'h0,          1'b0, 8'd11},  // R11 read old value
        '{1'b0, 1'b1, 12'h028, 32'h0,         32'h0000_0055, 1'b0, 8'd11},  // R11 write landed
        '{1'b1, 1'b0, 12'h000, 32'hDEAD_BEEF, 32'h0,          1'b0, 8'd2 },  // R2 slot 0
        '{1'b0, 1'b1, 12'h00C, 32'h0,         32'hDEAD_BEEF, 1'b0, 8'd6 },  // R6
        '{1'b0, 1'b1, 12'h010, 32'h0,         32'hFA5A_00F0, 1'b0, 8'd1 }   // R1 slot 1 independent
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = w;
        rd_en   = r;
        addr    = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rd_data, 32'h0, "R7 rd_data after reset");
        check({31'h0, err}, 32'h0, "R7 err after reset");
        for (int i = 0; i < NREG; i++) begin
            bus(1'b0, 1'b1, 12'(i * 16), 32'h0);
            check(rd_data, 32'h0, "R7 register zero after reset");
        end

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i].wr, VEC[i].rd, VEC[i].a, VEC[i].d);
            if (VEC[i].rd)
                check(rd_data, VEC[i].exp_rd, $sformatf("R%0d vector %0d rd_data", VEC[i].req, i));
            check({31'h0, err}, {31'h0, VEC[i].exp_err}, $sformatf("R%0d vector %0d err", VEC[i].req, i));
        end

        // R6 rd_data holds while idle; R10 err lasts one cycle
        bus(1'b0, 1'b1, 12'h0A0, 32'h0);
        check({31'h0, err}, 32'h1, "R10 err after out-of-range read");
        bus(1'b0, 1'b1, 12'h010, 32'h0);
        check({31'h0, err}, 32'h0, "R10 err dropped after one cycle");
        bus(1'b0, 1'b0, 12'h000, 32'h0);
        check(rd_data, 32'hFA5A_00F0, "R6 rd_data held while idle");
        check({31'h0, err}, 32'h0, "R10 no err when idle");

        // R5 double toggle restores
        bus(1'b1, 1'b0, 12'h03C, 32'h0F0F_0F0F);
        bus(1'b1, 1'b0, 12'h03C, 32'h0F0F_0F0F);
        bus(1'b0, 1'b1, 12'h034, 32'h0);
        check(rd_data, 32'h0, "R5 toggle twice returns to zero");

        // R7 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(rd_data, 32'h0, "R7 rd_data cleared by reset");
        bus(1'b0, 1'b1, 12'h010, 32'h0);
        check(rd_data, 32'h0, "R7 slot 1 cleared by reset");
        bus(1'b0, 1'b1, 12'h000, 32'h0);
        check(rd_data, 32'h0, "R7 slot 0 cleared by reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule